// File: doc/BRIEF.md
# Serial Flash Host-Link Front-End

This block is the pin-side front-end of a serial flash device. It watches the chip-select and serial-clock levels, which arrive already synchronised to the core clock. It takes command, address and write bytes from the host and hands them to a command decoder as whole parallel bytes. It also serialises read bytes that come back from that decoder. Transfers use one data line, or two lines in the paired modes: for a dual-lane read, the input pad also drives data, and for a dual-lane program, the output pad also takes data in.

The decoder receives a pulse when a frame opens, a pulse when it closes, an abort pulse when a frame closes in the middle of a byte, and a strobe with each complete byte. After the decoder has seen the opcode, it picks the lane mode. It feeds read bytes through a hold register that the block empties with a take pulse. A busy input from the self-timed program/erase engine keeps the standby indication low until that engine is done.

Top module: `spi_flash_front`

## Requirements
- R1: While `rst_n` is low, `so_oe`, `si_oe`, `rx_valid`, `tx_take`, `frame_start`, `frame_end` and `frame_abort` are 0.
- R2: A falling edge on `cs_n` gives a one-cycle `frame_start` pulse. A rising edge gives a one-cycle `frame_end` pulse.
- R3: In single-lane mode (`mode_sel` code 0, and the default), `si_in` is sampled on each rising SCK edge, most-significant bit first. After every 8th rising edge, `rx_valid` pulses for one cycle with the assembled byte on `rx_data`.
- R4: In dual-in mode (code 1), each rising SCK edge takes two bits: `si_in` is the higher bit of the pair and `so_in` the lower. A byte completes every 4 rising edges.
- R5: While `tx_enable` is high, the falling SCK edge that starts a byte loads `tx_data` and pulses `tx_take`. In single-lane mode, `so_out` then presents one bit per falling edge, most-significant first, and `so_oe` is 1 while `si_oe` is 0.
- R6: In dual-out mode (code 2), each falling SCK edge presents two bits: `si_out` carries the higher bit and `so_out` the lower. Both output enables are 1.
- R7: While `cs_n` is high, both output enables are 0. SCK activity and `si_in` are ignored: no byte is strobed and no bit is counted.
- R8: If `cs_n` rises with a partial byte, `frame_abort` pulses together with `frame_end`. The partial bits are discarded, and the next frame starts at bit 0.
- R9: A `mode_load` pulse only takes effect after the first byte of the frame has been strobed. The lane mode goes back to single-lane at every `cs_n` rise.
- R10: `standby` is 1 only when `cs_n` is high and `busy` is low. If `busy` is high when `cs_n` rises, `standby` stays 0 until `busy` clears.
- R11: Both idle polarities of SCK are accepted. With SCK high when `cs_n` falls, the first falling edge is not counted as a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Synchronised serial clock |
| cs_n | input | 1 | Synchronised chip select, active low |
| si_in | input | 1 | Serial input pad, input path |
| si_out | output | 1 | Serial input pad, output path (dual-out) |
| si_oe | output | 1 | Output enable for the serial input pad |
| so_in | input | 1 | Serial output pad, input path (dual-in) |
| so_out | output | 1 | Serial output pad, output path |
| so_oe | output | 1 | Output enable for the serial output pad |
| busy | input | 1 | Self-timed operation in progress |
| standby | output | 1 | Device deselected and idle |
| rx_data | output | BYTE_W | Received byte |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| frame_start | output | 1 | Chip-select fall pulse |
| frame_end | output | 1 | Chip-select rise pulse |
| frame_abort | output | 1 | Frame closed mid-byte |
| mode_load | input | 1 | Latch mode_sel |
| mode_sel | input | 2 | Lane mode: 0 single, 1 dual-in, 2 dual-out, 3 single |
| tx_enable | input | 1 | Read phase active |
| tx_data | input | BYTE_W | Next byte to send |
| tx_take | output | 1 | tx_data has been loaded |

## Verification
The assertions assume that `sck` and `cs_n` come from the same synchroniser and that each SCK level lasts at least two core-clock cycles. They also assume that `cs_n` never changes on the same core-clock edge as an SCK edge, and that the pad inputs are stable whenever SCK rises. The bench changes every input on the falling core-clock edge and holds each SCK phase for two cycles. It changes data only together with SCK falling, and it moves `cs_n` only while SCK is idle. That keeps the stimulus inside those assumptions for both clock polarities.

// File: rtl/sfe_pkg.sv
// Shared types for the serial flash front-end.
package sfe_pkg;
    typedef enum logic [1:0] {
        LANE_SINGLE   = 2'd0,
        LANE_DUAL_IN  = 2'd1,
        LANE_DUAL_OUT = 2'd2
    } lane_mode_e;
endpackage

// File: rtl/sfe_edge_bank.sv
// Edge detector bank: reports rise and fall of N level signals.
// Assumes the inputs are already synchronous to clk. The history register
// has no reset, so no edge appears at reset release.
module sfe_edge_bank #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev;

    // Keep last sampled level of every input.
    always_ff @(posedge clk) begin
        prev <= lvl;
    end

    // Per-bit edge decode.
    for (genvar g = 0; g < N; g++) begin : g_edge
        assign rise[g] = lvl[g] & ~prev[g];
        assign fall[g] = ~lvl[g] & prev[g];
    end
endmodule

// File: rtl/sfe_rx_shift.sv
// Receive shifter: assembles bytes MSB first from one or two lines.
// In dual mode the si line carries the higher bit of each pair.
// Assumes BYTE_W is a power of two and at least 4, and that the mode does
// not change in the middle of a byte.
module sfe_rx_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic              clear,
    input  logic              dual,
    input  logic              si,
    input  logic              so,
    output logic [BYTE_W-1:0] data,
    output logic              valid,
    output logic              partial
);
    localparam int CW = $clog2(BYTE_W);

    logic [CW-1:0]     cnt;
    logic [CW-1:0]     step;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] nxt;
    logic              last;

    // Next shift value and bit advance for the selected lane count.
    always_comb begin
        if (dual) begin
            nxt  = {sh[BYTE_W-3:0], si, so};
            step = CW'(2);
        end else begin
            nxt  = {sh[BYTE_W-2:0], si};
            step = CW'(1);
        end
        last = (CW'(cnt + step) == '0);
    end

    assign partial = (cnt != '0);

    // Shift, count, and strobe completed bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            sh    <= '0;
            data  <= '0;
            valid <= 1'b0;
        end else if (clear) begin
            cnt   <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (sample) begin
                sh  <= nxt;
                cnt <= cnt + step;
                if (last) begin
                    data  <= nxt;
                    valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sfe_tx_shift.sv
// Transmit shifter: serialises bytes MSB first onto one or two lines.
// The first shift of a byte loads data_in and pulses take.
// hi_bit goes to the si pad (dual only). lo_bit goes to the so pad.
// Assumes the mode is fixed for a whole byte.
module sfe_tx_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift,
    input  logic              clear,
    input  logic              dual,
    input  logic [BYTE_W-1:0] data_in,
    output logic              hi_bit,
    output logic              lo_bit,
    output logic              take,
    output logic              active
);
    localparam int CW = $clog2(BYTE_W);

    logic [CW-1:0]     cnt;
    logic [CW-1:0]     step;
    logic [BYTE_W-1:0] src;
    logic [BYTE_W-1:0] sh;

    // Pick the fresh byte at a byte boundary, else the shifter.
    always_comb begin
        src  = (cnt == '0) ? data_in : sh;
        step = dual ? CW'(2) : CW'(1);
    end

    // Drive bits on each shift request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            sh     <= '0;
            hi_bit <= 1'b0;
            lo_bit <= 1'b0;
            take   <= 1'b0;
            active <= 1'b0;
        end else if (clear) begin
            cnt    <= '0;
            hi_bit <= 1'b0;
            lo_bit <= 1'b0;
            take   <= 1'b0;
            active <= 1'b0;
        end else begin
            take <= 1'b0;
            if (shift) begin
                active <= 1'b1;
                take   <= (cnt == '0);
                hi_bit <= src[BYTE_W-1];
                lo_bit <= dual ? src[BYTE_W-2] : src[BYTE_W-1];
                sh     <= dual ? (src << 2) : (src << 1);
                cnt    <= cnt + step;
            end
        end
    end
endmodule

// File: rtl/spi_flash_front.sv
// Serial flash host-link front-end.
// Detects chip-select framing and SCK edges from synchronised levels,
// receives bytes on rising SCK, and sends bytes on falling SCK.
// Each transfer uses one lane, or two when the decoder selects a dual mode.
// Reports standby only when deselected and the self-timed engine is idle.
// Assumes sck and cs_n share one synchroniser and each SCK phase lasts
// at least two clk cycles.
module spi_flash_front
    import sfe_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si_in,
    output logic              si_out,
    output logic              si_oe,
    input  logic              so_in,
    output logic              so_out,
    output logic              so_oe,
    input  logic              busy,
    output logic              standby,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              frame_start,
    output logic              frame_end,
    output logic              frame_abort,
    input  logic              mode_load,
    input  logic [1:0]        mode_sel,
    input  logic              tx_enable,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_take
);
    localparam int SCK_IDX = 0;
    localparam int CS_IDX  = 1;

    logic [1:0] lvl, rise, fall;
    logic       sel, cs_open, cs_close, sck_up, sck_dn;
    lane_mode_e mode_q, mode_req;
    logic       opcode_seen;
    logic       rx_partial;
    logic       tx_hi, tx_lo, tx_active;

    assign lvl = {cs_n, sck};

    sfe_edge_bank #(.N(2)) u_edges (
        .clk  (clk),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    assign sel      = ~cs_n;
    assign cs_open  = fall[CS_IDX];
    assign cs_close = rise[CS_IDX];
    assign sck_up   = rise[SCK_IDX] & sel;
    assign sck_dn   = fall[SCK_IDX] & sel;

    // Map the decoder's mode code; the spare code falls back to single lane.
    always_comb begin
        case (mode_sel)
            2'd1:    mode_req = LANE_DUAL_IN;
            2'd2:    mode_req = LANE_DUAL_OUT;
            default: mode_req = LANE_SINGLE;
        endcase
    end

    // Lane mode register: loads after the opcode, clears at frame close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= LANE_SINGLE;
            opcode_seen <= 1'b0;
        end else if (cs_close) begin
            mode_q      <= LANE_SINGLE;
            opcode_seen <= 1'b0;
        end else begin
            if (rx_valid)
                opcode_seen <= 1'b1;
            if (mode_load && sel && (opcode_seen || rx_valid))
                mode_q <= mode_req;
        end
    end

    sfe_rx_shift #(.BYTE_W(BYTE_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample  (sck_up && (mode_q != LANE_DUAL_OUT)),
        .clear   (cs_close),
        .dual    (mode_q == LANE_DUAL_IN),
        .si      (si_in),
        .so      (so_in),
        .data    (rx_data),
        .valid   (rx_valid),
        .partial (rx_partial)
    );

    sfe_tx_shift #(.BYTE_W(BYTE_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift   (sck_dn && tx_enable),
        .clear   (cs_close),
        .dual    (mode_q == LANE_DUAL_OUT),
        .data_in (tx_data),
        .hi_bit  (tx_hi),
        .lo_bit  (tx_lo),
        .take    (tx_take),
        .active  (tx_active)
    );

    assign so_out = tx_lo;
    assign si_out = tx_hi;
    assign so_oe  = tx_active;
    assign si_oe  = tx_active && (mode_q == LANE_DUAL_OUT);

    // Frame event pulses and standby indication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_start <= 1'b0;
            frame_end   <= 1'b0;
            frame_abort <= 1'b0;
            standby     <= 1'b0;
        end else begin
            frame_start <= cs_open;
            frame_end   <= cs_close;
            frame_abort <= cs_close && rx_partial;
            standby     <= cs_n && !busy;
        end
    end
endmodule

// File: rtl/sfe_checker.sv
// Protocol checker for spi_flash_front, attached by bind.
// Assumes each SCK phase lasts at least two clk cycles.
module sfe_checker #(
    parameter int BYTE_W = 8
) (
    input logic clk,
    input logic rst_n,
    input logic sck,
    input logic cs_n,
    input logic busy,
    input logic so_oe,
    input logic si_oe,
    input logic standby,
    input logic rx_valid,
    input logic tx_take,
    input logic frame_start,
    input logic frame_end,
    input logic frame_abort
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n && !$past(rst_n) |-> !rx_valid && !frame_start && !frame_end);

    assert_start_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !$past(cs_n) && $past(cs_n, 2));

    assert_end_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> $past(cs_n) && !$past(cs_n, 2));

    assert_strobe_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(sck) && !$past(sck, 2) && !$past(cs_n));

    assert_take_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |-> !$past(sck) && $past(sck, 2));

    assert_dual_oe_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        si_oe |-> so_oe);

    assert_hiz_deselect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n && $past(cs_n) |-> !so_oe && !si_oe);

    assert_abort_with_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_abort |-> frame_end);

    assert_standby_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> $past(cs_n) && !$past(busy));

    assert_frame_pulse_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_start, frame_end}));
endmodule

bind spi_flash_front sfe_checker #(.BYTE_W(BYTE_W)) u_sfe_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .sck         (sck),
    .cs_n        (cs_n),
    .busy        (busy),
    .so_oe       (so_oe),
    .si_oe       (si_oe),
    .standby     (standby),
    .rx_valid    (rx_valid),
    .tx_take     (tx_take),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .frame_abort (frame_abort)
);

// File: tb/tb_spi_flash_front.sv
// Directed bench for spi_flash_front.
module tb_spi_flash_front;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic       si_in = 1'b0;
    logic       so_in = 1'b0;
    logic       busy = 1'b0;
    logic       mode_load = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic       tx_enable = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       si_out, si_oe, so_out, so_oe, standby;
    logic [7:0] rx_data;
    logic       rx_valid, frame_start, frame_end, frame_abort, tx_take;

    int n_checks = 0;
    int n_fail   = 0;
    int n_fs = 0, n_fe = 0, n_fa = 0, n_take = 0, n_log = 0;
    logic [7:0] rx_log [0:63];
    int cycles = 0;

    always #2.5 clk = ~clk;

    spi_flash_front #(.BYTE_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
        .si_in(si_in), .si_out(si_out), .si_oe(si_oe),
        .so_in(so_in), .so_out(so_out), .so_oe(so_oe),
        .busy(busy), .standby(standby),
        .rx_data(rx_data), .rx_valid(rx_valid),
        .frame_start(frame_start), .frame_end(frame_end), .frame_abort(frame_abort),
        .mode_load(mode_load), .mode_sel(mode_sel),
        .tx_enable(tx_enable), .tx_data(tx_data), .tx_take(tx_take)
    );

    // Event monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid && n_log < 64) begin
                rx_log[n_log] = rx_data;
                n_log++;
            end
            if (frame_start) n_fs++;
            if (frame_end)   n_fe++;
            if (frame_abort) n_fa++;
            if (tx_take)     n_take++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_sck(input logic v);
        sck = v;
        waitc(2);
    endtask

    task automatic send_single(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0; si_in = b[i];
            waitc(2);
            set_sck(1'b1);
        end
    endtask

    task automatic send_dual(input logic [7:0] b);
        for (int k = 0; k < 4; k++) begin
            sck = 1'b0; si_in = b[7-2*k]; so_in = b[6-2*k];
            waitc(2);
            set_sck(1'b1);
        end
    endtask

    task automatic read_single(output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            set_sck(1'b0);
            b[i] = so_out;
            set_sck(1'b1);
        end
    endtask

    task automatic read_dual(output logic [7:0] b);
        for (int k = 0; k < 4; k++) begin
            set_sck(1'b0);
            b[7-2*k] = si_out;
            b[6-2*k] = so_out;
            set_sck(1'b1);
        end
    endtask

    task automatic open_frame();
        cs_n = 1'b0;
        waitc(2);
    endtask

    task automatic close_frame_m0();
        set_sck(1'b0);
        cs_n = 1'b1;
        waitc(3);
    endtask

    task automatic load_mode(input logic [1:0] m);
        mode_sel = m; mode_load = 1'b1;
        waitc(1);
        mode_load = 1'b0;
        waitc(1);
    endtask

    task automatic t_reset();
        waitc(3);
        chk(so_oe == 0 && si_oe == 0, "R1 oe in reset", {so_oe, si_oe}, 0);
        chk(rx_valid == 0 && tx_take == 0, "R1 strobes in reset", {rx_valid, tx_take}, 0);
        chk(frame_start == 0 && frame_end == 0 && frame_abort == 0, "R1 frame pulses in reset",
            {frame_start, frame_end, frame_abort}, 0);
        rst_n = 1'b1;
        waitc(3);
    endtask

    task automatic t_single_rx();
        int fs0 = n_fs, fe0 = n_fe, lg0 = n_log;
        open_frame();
        chk(n_fs == fs0 + 1, "R2 frame_start count", n_fs - fs0, 1);
        send_single(8'hA5);
        send_single(8'h3C);
        close_frame_m0();
        chk(n_fe == fe0 + 1, "R2 frame_end count", n_fe - fe0, 1);
        chk(n_log == lg0 + 2, "R3 byte count", n_log - lg0, 2);
        chk(rx_log[lg0] == 8'hA5, "R3 first byte", rx_log[lg0], 8'hA5);
        chk(rx_log[lg0+1] == 8'h3C, "R3 second byte", rx_log[lg0+1], 8'h3C);
    endtask

    task automatic t_dual_in();
        int lg0 = n_log;
        open_frame();
        send_single(8'h12);
        load_mode(2'd1);
        send_dual(8'hC9);
        send_dual(8'h5E);
        close_frame_m0();
        chk(n_log == lg0 + 3, "R4 byte count", n_log - lg0, 3);
        chk(rx_log[lg0+1] == 8'hC9, "R4 dual byte 1", rx_log[lg0+1], 8'hC9);
        chk(rx_log[lg0+2] == 8'h5E, "R4 dual byte 2", rx_log[lg0+2], 8'h5E);
        open_frame();
        send_single(8'h81);
        close_frame_m0();
        chk(rx_log[lg0+3] == 8'h81, "R9 mode cleared at close", rx_log[lg0+3], 8'h81);
    endtask

    task automatic t_early_mode();
        int lg0 = n_log;
        open_frame();
        load_mode(2'd1);
        send_single(8'h96);
        close_frame_m0();
        chk(n_log == lg0 + 1 && rx_log[lg0] == 8'h96, "R9 early mode_load ignored",
            rx_log[lg0], 8'h96);
    endtask

    task automatic t_single_read();
        logic [7:0] got;
        int tk0 = n_take;
        open_frame();
        send_single(8'h03);
        tx_data = 8'hB4; tx_enable = 1'b1;
        read_single(got);
        chk(got == 8'hB4, "R5 read byte 1", got, 8'hB4);
        chk(so_oe == 1 && si_oe == 0, "R5 enables single", {so_oe, si_oe}, 2'b10);
        tx_data = 8'h6D;
        read_single(got);
        chk(got == 8'h6D, "R5 read byte 2", got, 8'h6D);
        chk(n_take == tk0 + 2, "R5 take count", n_take - tk0, 2);
        tx_enable = 1'b0;
        close_frame_m0();
        chk(so_oe == 0 && si_oe == 0, "R7 enables off after close", {so_oe, si_oe}, 0);
    endtask

    task automatic t_dual_read();
        logic [7:0] got;
        open_frame();
        send_single(8'h3B);
        load_mode(2'd2);
        tx_data = 8'h9C; tx_enable = 1'b1;
        read_dual(got);
        chk(got == 8'h9C, "R6 dual read byte", got, 8'h9C);
        chk(so_oe == 1 && si_oe == 1, "R6 both enables", {so_oe, si_oe}, 2'b11);
        tx_enable = 1'b0;
        close_frame_m0();
        chk(si_oe == 0, "R7 si_oe off after close", si_oe, 0);
    endtask

    task automatic t_deselect_ignore();
        int lg0 = n_log, fs0 = n_fs;
        si_in = 1'b1;
        for (int i = 0; i < 5; i++) begin
            set_sck(1'b1);
            set_sck(1'b0);
        end
        chk(n_log == lg0 && n_fs == fs0, "R7 no activity while deselected", n_log - lg0, 0);
        chk(so_oe == 0, "R7 so_oe off while deselected", so_oe, 0);
        open_frame();
        send_single(8'h42);
        close_frame_m0();
        chk(rx_log[lg0] == 8'h42, "R7 bits not counted while deselected", rx_log[lg0], 8'h42);
    endtask

    task automatic t_abort();
        int lg0 = n_log, fa0 = n_fa, fe0 = n_fe;
        open_frame();
        for (int i = 0; i < 3; i++) begin
            sck = 1'b0; si_in = 1'b1;
            waitc(2);
            set_sck(1'b1);
        end
        close_frame_m0();
        chk(n_fa == fa0 + 1 && n_fe == fe0 + 1, "R8 abort with end", n_fa - fa0, 1);
        chk(n_log == lg0, "R8 partial byte dropped", n_log - lg0, 0);
        open_frame();
        send_single(8'h7E);
        close_frame_m0();
        chk(rx_log[lg0] == 8'h7E && n_fa == fa0 + 1, "R8 restart at bit 0", rx_log[lg0], 8'h7E);
    endtask

    task automatic t_standby();
        busy = 1'b1;
        waitc(2);
        chk(standby == 0, "R10 busy blocks standby", standby, 0);
        busy = 1'b0;
        waitc(2);
        chk(standby == 1, "R10 idle standby", standby, 1);
        open_frame();
        chk(standby == 0, "R10 selected not standby", standby, 0);
        busy = 1'b1;
        waitc(1);
        cs_n = 1'b1;
        waitc(4);
        chk(standby == 0, "R10 stays low while busy", standby, 0);
        busy = 1'b0;
        waitc(2);
        chk(standby == 1, "R10 standby after busy clears", standby, 1);
    endtask

    task automatic t_mode3();
        int lg0 = n_log, fa0 = n_fa;
        set_sck(1'b1);
        open_frame();
        send_single(8'hE1);
        cs_n = 1'b1;
        waitc(3);
        chk(n_log == lg0 + 1 && rx_log[lg0] == 8'hE1, "R11 high-idle clock byte", rx_log[lg0], 8'hE1);
        chk(n_fa == fa0, "R11 no abort at high-idle close", n_fa - fa0, 0);
        set_sck(1'b0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cycles, 100000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_single_rx();
        t_dual_in();
        t_early_mode();
        t_single_read();
        t_dual_read();
        t_deselect_ignore();
        t_abort();
        t_standby();
        t_mode3();
        waitc(4);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule